// File: doc/BRIEF.md
# Three-Wire Panel Register Writer

This block is a serial command master that loads 8-bit values into 8-bit configuration registers of a display panel. The panel is reached over three wires: an active-low select, a serial clock and a serial data line. Software or a power manager asks for one of three operations:

- a single write, with an address and a data byte;
- the built-in power-up script;
- the built-in power-down script.

The block then produces the matching frames on the wire.

Every frame carries sixteen bits. The register address is the upper byte, the value is the lower byte, and the most significant bit goes first. The serial clock half-period is set in system clocks by a divider input. While an operation runs, `busy` stays high. When the operation finishes, `done` pulses for one cycle.

Top module: `panel_cfg_writer`

## Requirements
- R1: After reset and whenever `busy` is low, the lines rest at select high, serial clock high and data low.
- R2: A frame begins when select falls and ends when select rises. It holds exactly 16 rising edges of the serial clock. The bits sampled on those edges are address[7:0] followed by data[7:0], most significant bit first.
- R3: The data line changes only while the serial clock is low or select is high. While select is low and the clock is high, data is stable, so the panel samples on the rising edge.
- R4: Each serial clock low phase lasts max(1, `half_div`) system clocks. A value of 0 acts as 1.
- R5: The power-up request (`on_req`) sends five frames in this order: (0x05,0x1E), (0x05,0x5E), (0x07,0x8D), (0x13,0x01), (0x05,0x5F).
- R6: The power-down request (`off_req`) sends the single frame (0x05,0x5E).
- R7: Between consecutive frames of one script, select stays high for at least max(1, `half_div`) system clocks.
- R8: `busy` rises in the cycle after a request is accepted and covers every frame of the operation. Requests that arrive while `busy` is high are ignored and produce no frame.
- R9: `done` is a one-cycle pulse given once per completed operation, in the cycle in which `busy` falls.
- R10: Requests that arrive in the same idle cycle are served in this priority order: single write, then power-up, then power-down. Only one of them is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_req | input | 1 | Single-write request |
| wr_addr | input | 8 | Register address for a single write |
| wr_data | input | 8 | Register value for a single write |
| on_req | input | 1 | Start the power-up script |
| off_req | input | 1 | Start the power-down script |
| half_div | input | DIV_W | Serial clock half-period in system clocks (0 treated as 1) |
| sel_n | output | 1 | Panel select, active low |
| ser_clk | output | 1 | Serial clock, idles high |
| ser_dat | output | 1 | Serial data, idles low |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench decodes frames from the three pins and compares them against a queue of expected words. It exercises:

- single writes whose data alternates or is all ones or all zeros, which exposes bit-order and shift errors;
- both scripts, which shows whether the order and content of the script table are right;
- divider values of 0, 1 and 3, which separates correct phase timing from off-by-one counting and from a missing clamp of zero;
- requests raised while busy and requests raised together, which shows whether ignored requests leak into frames and whether the priority holds.

// File: rtl/panel_cfg_pkg.sv
package panel_cfg_pkg;

   localparam int FRAME_BITS = 16;
   localparam int SCRIPT_LEN = 6;
   localparam int PTR_W      = 3;
   localparam logic [PTR_W-1:0] ON_FIRST  = 3'd0;
   localparam logic [PTR_W-1:0] ON_LAST   = 3'd4;
   localparam logic [PTR_W-1:0] OFF_FIRST = 3'd5;
   localparam logic [PTR_W-1:0] OFF_LAST  = 3'd5;

   typedef enum logic [2:0] {
      SER_IDLE,
      SER_LEAD,
      SER_LOW,
      SER_HIGH,
      SER_GAP
   } ser_state_t;

   // Entries 0..4: power-up order; entry 5: power-down.
   function automatic logic [FRAME_BITS-1:0] script_word(input logic [PTR_W-1:0] idx);
      logic [FRAME_BITS-1:0] w;
      case (idx)
         3'd0:    w = 16'h051E;
         3'd1:    w = 16'h055E;
         3'd2:    w = 16'h078D;
         3'd3:    w = 16'h1301;
         3'd4:    w = 16'h055F;
         3'd5:    w = 16'h055E;
         default: w = 16'h0000;
      endcase
      return w;
   endfunction

endpackage

// File: rtl/panel_cfg_seq.sv
module panel_cfg_seq
   import panel_cfg_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_req,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     on_req,
   input  logic                     off_req,
   input  logic                     frame_done,
   output logic                     launch,
   output logic [ADDR_W+DATA_W-1:0] word,
   output logic                     busy,
   output logic                     done
);

   localparam int WORD_W = ADDR_W + DATA_W;

   logic              single_q;
   logic [WORD_W-1:0] hold_q;
   logic [PTR_W-1:0]  ptr_q;
   logic [PTR_W-1:0]  last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         launch   <= 1'b0;
         single_q <= 1'b0;
         hold_q   <= '0;
         ptr_q    <= '0;
         last_q   <= '0;
      end else begin
         done   <= 1'b0;
         launch <= 1'b0;
         if (!busy) begin
            if (wr_req) begin
               busy     <= 1'b1;
               launch   <= 1'b1;
               single_q <= 1'b1;
               hold_q   <= {wr_addr, wr_data};
            end else if (on_req) begin
               busy     <= 1'b1;
               launch   <= 1'b1;
               single_q <= 1'b0;
               ptr_q    <= ON_FIRST;
               last_q   <= ON_LAST;
            end else if (off_req) begin
               busy     <= 1'b1;
               launch   <= 1'b1;
               single_q <= 1'b0;
               ptr_q    <= OFF_FIRST;
               last_q   <= OFF_LAST;
            end
         end else if (frame_done) begin
            if (single_q || ptr_q == last_q) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               ptr_q  <= ptr_q + 1'b1;
               launch <= 1'b1;
            end
         end
      end
   end

   assign word = single_q ? hold_q : WORD_W'(script_word(ptr_q));

endmodule

// File: rtl/panel_cfg_ser.sv
module panel_cfg_ser
   import panel_cfg_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] word,
   input  logic [DIV_W-1:0]  half_div,
   output logic              sel_n,
   output logic              ser_clk,
   output logic              ser_dat,
   output logic              frame_done
);

   localparam int BIT_W = $clog2(WORD_W);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

   logic [DIV_W-1:0] eff_div;

   generate
      if (DIV_W == 1) begin : g_div_fixed
         assign eff_div = 1'b1;
      end else begin : g_div_clamp
         assign eff_div = (half_div == '0) ? DIV_W'(1) : half_div;
      end
   endgenerate

   ser_state_t        state_q;
   logic [DIV_W-1:0]  reload_q;
   logic [DIV_W-1:0]  cnt_q;
   logic [WORD_W-1:0] shift_q;
   logic [BIT_W-1:0]  bit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SER_IDLE;
         reload_q   <= DIV_W'(1);
         cnt_q      <= '0;
         shift_q    <= '0;
         bit_q      <= '0;
         sel_n      <= 1'b1;
         ser_clk    <= 1'b1;
         ser_dat    <= 1'b0;
         frame_done <= 1'b0;
      end else begin
         frame_done <= 1'b0;
         case (state_q)
            SER_IDLE: begin
               if (start) begin
                  shift_q  <= word;
                  reload_q <= eff_div;
                  cnt_q    <= eff_div - 1'b1;
                  bit_q    <= '0;
                  sel_n    <= 1'b0;
                  state_q  <= SER_LEAD;
               end
            end
            SER_LEAD: begin
               if (cnt_q == '0) begin
                  ser_clk <= 1'b0;
                  ser_dat <= shift_q[WORD_W-1];
                  cnt_q   <= reload_q - 1'b1;
                  state_q <= SER_LOW;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            SER_LOW: begin
               if (cnt_q == '0) begin
                  ser_clk <= 1'b1;
                  cnt_q   <= reload_q - 1'b1;
                  state_q <= SER_HIGH;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            SER_HIGH: begin
               if (cnt_q == '0) begin
                  cnt_q <= reload_q - 1'b1;
                  if (bit_q == LAST_BIT) begin
                     sel_n   <= 1'b1;
                     ser_dat <= 1'b0;
                     state_q <= SER_GAP;
                  end else begin
                     bit_q   <= bit_q + 1'b1;
                     shift_q <= {shift_q[WORD_W-2:0], 1'b0};
                     ser_clk <= 1'b0;
                     ser_dat <= shift_q[WORD_W-2];
                     state_q <= SER_LOW;
                  end
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            SER_GAP: begin
               if (cnt_q == '0) begin
                  frame_done <= 1'b1;
                  state_q    <= SER_IDLE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: state_q <= SER_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/panel_cfg_writer.sv
module panel_cfg_writer #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              on_req,
   input  logic              off_req,
   input  logic [DIV_W-1:0]  half_div,
   output logic              sel_n,
   output logic              ser_clk,
   output logic              ser_dat,
   output logic              busy,
   output logic              done
);

   localparam int WORD_W = ADDR_W + DATA_W;

   generate
      if (ADDR_W != 8 || DATA_W != 8) begin : g_bad_width
         $error("panel_cfg_writer: script table needs 8-bit address and data");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("panel_cfg_writer: DIV_W must be at least 1");
      end
   endgenerate

   logic              launch;
   logic              frame_done;
   logic [WORD_W-1:0] word;

   panel_cfg_seq #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_req    (wr_req),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .on_req    (on_req),
      .off_req   (off_req),
      .frame_done(frame_done),
      .launch    (launch),
      .word      (word),
      .busy      (busy),
      .done      (done)
   );

   panel_cfg_ser #(
      .WORD_W(WORD_W),
      .DIV_W (DIV_W)
   ) i_ser (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (launch),
      .word      (word),
      .half_div  (half_div),
      .sel_n     (sel_n),
      .ser_clk   (ser_clk),
      .ser_dat   (ser_dat),
      .frame_done(frame_done)
   );

endmodule

// File: rtl/panel_cfg_writer_chk.sv
module panel_cfg_writer_chk (
   input logic clk,
   input logic rst_n,
   input logic sel_n,
   input logic ser_clk,
   input logic ser_dat,
   input logic busy,
   input logic done
);

   // R1
   idle_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sel_n && ser_clk && !ser_dat));

   // R3
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n && ser_clk && $past(!sel_n && ser_clk)) |-> $stable(ser_dat));

   // R8
   frame_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_n |-> busy);

   // R9
   done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

bind panel_cfg_writer panel_cfg_writer_chk i_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .sel_n  (sel_n),
   .ser_clk(ser_clk),
   .ser_dat(ser_dat),
   .busy   (busy),
   .done   (done)
);

// File: tb/test_panel_cfg_writer.sv
module test_panel_cfg_writer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_req = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       on_req = 1'b0;
   logic       off_req = 1'b0;
   logic [7:0] half_div = 8'd1;
   logic       sel_n, ser_clk, ser_dat, busy, done;

   int checks = 0;
   int failures = 0;
   int cur_eff = 1;
   int done_cnt = 0;
   int frame_cnt = 0;
   logic [15:0] exp_q[$];

   always #5 clk = ~clk;

   panel_cfg_writer i_panel_cfg_writer (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
      .wr_data(wr_data), .on_req(on_req), .off_req(off_req),
      .half_div(half_div), .sel_n(sel_n), .ser_clk(ser_clk),
      .ser_dat(ser_dat), .busy(busy), .done(done)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // Monitor: decodes frames from the pins, pops expected words.
   logic        prev_sel = 1'b1, prev_clk = 1'b1;
   logic [15:0] shift = '0;
   int          bits = 0, low_run = 0, gap_run = 0;
   bit          had_frame = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (done) done_cnt++;
         if (prev_sel && !sel_n) begin
            bits = 0;
            shift = '0;
            low_run = 0;
            if (had_frame) check(gap_run >= cur_eff, "R7 gap", gap_run, cur_eff);
            gap_run = 0;
         end
         if (!sel_n && !ser_clk) low_run++;
         if (!sel_n && !prev_clk && ser_clk) begin
            shift = {shift[14:0], ser_dat};
            bits++;
            check(low_run == cur_eff, "R4 low phase", low_run, cur_eff);
            low_run = 0;
         end
         if (!prev_sel && sel_n) begin
            frame_cnt++;
            had_frame = 1;
            check(bits == 16, "R2 bit count", bits, 16);
            if (exp_q.size() == 0) begin
               check(0, "R8 unexpected frame", shift, 0);
            end else begin
               logic [15:0] e;
               e = exp_q.pop_front();
               check(shift == e, "R2 frame word", shift, e);
            end
         end
         if (sel_n && busy) gap_run++;
         if (!busy) begin
            had_frame = 0;
            gap_run = 0;
         end
         prev_sel = sel_n;
         prev_clk = ser_clk;
      end
   end

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic do_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_addr = a; wr_data = d; wr_req = 1'b1;
      exp_q.push_back({a, d});
      @(negedge clk);
      wr_req = 1'b0;
      check(busy == 1'b1, "R8 busy after request", busy, 1);
      wait_idle();
   endtask

   task automatic do_on();
      @(negedge clk);
      on_req = 1'b1;
      exp_q.push_back(16'h051E); exp_q.push_back(16'h055E);
      exp_q.push_back(16'h078D); exp_q.push_back(16'h1301);
      exp_q.push_back(16'h055F);
      @(negedge clk);
      on_req = 1'b0;
   endtask

   initial begin
      int d0, f0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(sel_n == 1'b1, "R1 sel idle", sel_n, 1);
      check(ser_clk == 1'b1, "R1 clk idle", ser_clk, 1);
      check(ser_dat == 1'b0, "R1 dat idle", ser_dat, 0);
      check(busy == 1'b0, "R1 busy idle", busy, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 R4 R9: single writes, several patterns and dividers
      d0 = done_cnt;
      half_div = 8'd1; cur_eff = 1;
      do_write(8'hA5, 8'h5A);
      do_write(8'hFF, 8'h00);
      half_div = 8'd3; cur_eff = 3;
      do_write(8'h00, 8'hFF);
      do_write(8'h81, 8'h7E);
      half_div = 8'd0; cur_eff = 1;
      do_write(8'h3C, 8'hC3);
      @(negedge clk);
      check(done_cnt - d0 == 5, "R9 done per write", done_cnt - d0, 5);

      // R5 R7: power-up script with divider 2
      half_div = 8'd2; cur_eff = 2;
      d0 = done_cnt; f0 = frame_cnt;
      do_on();
      wait_idle();
      @(negedge clk);
      check(frame_cnt - f0 == 5, "R5 script frames", frame_cnt - f0, 5);
      check(done_cnt - d0 == 1, "R9 one done per script", done_cnt - d0, 1);

      // R6: power-down script
      f0 = frame_cnt;
      @(negedge clk);
      off_req = 1'b1; exp_q.push_back(16'h055E);
      @(negedge clk);
      off_req = 1'b0;
      wait_idle();
      @(negedge clk);
      check(frame_cnt - f0 == 1, "R6 off frames", frame_cnt - f0, 1);

      // R8: requests while busy are ignored
      f0 = frame_cnt;
      do_on();
      repeat (10) @(negedge clk);
      wr_addr = 8'hAA; wr_data = 8'hBB; wr_req = 1'b1; off_req = 1'b1;
      @(negedge clk);
      wr_req = 1'b0; off_req = 1'b0;
      wait_idle();
      repeat (60) @(negedge clk);
      check(frame_cnt - f0 == 5, "R8 ignored while busy", frame_cnt - f0, 5);
      check(sel_n == 1'b1 && busy == 1'b0, "R1 idle after run", {sel_n, busy}, 2'b10);

      // R10: simultaneous requests, single write wins
      f0 = frame_cnt;
      @(negedge clk);
      wr_addr = 8'h12; wr_data = 8'h34; wr_req = 1'b1; on_req = 1'b1; off_req = 1'b1;
      exp_q.push_back(16'h1234);
      @(negedge clk);
      wr_req = 1'b0; on_req = 1'b0; off_req = 1'b0;
      wait_idle();
      repeat (40) @(negedge clk);
      check(frame_cnt - f0 == 1, "R10 write priority", frame_cnt - f0, 1);

      // R10: on beats off
      f0 = frame_cnt;
      @(negedge clk);
      on_req = 1'b1; off_req = 1'b1;
      exp_q.push_back(16'h051E); exp_q.push_back(16'h055E);
      exp_q.push_back(16'h078D); exp_q.push_back(16'h1301);
      exp_q.push_back(16'h055F);
      @(negedge clk);
      on_req = 1'b0; off_req = 1'b0;
      wait_idle();
      repeat (40) @(negedge clk);
      check(frame_cnt - f0 == 5, "R10 on over off", frame_cnt - f0, 5);
      check(exp_q.size() == 0, "R2 all expected frames seen", exp_q.size(), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule